// File: doc/BRIEF.md
# Field-Coupled Nanomagnet Cell Resolver

This block is a discrete, cycle-based behavioural model of a single field-coupled magnetic logic cell. It holds one cell state and sees three neighbour cells through two-bit ports. It drives its own state to the downstream neighbour on a fourth, registered port. The cell can be forced to logic one or logic zero by single-cycle write strobes. It can also be parked in the clocked (energy-maximum) state by a park command. When the park command is released, the cell settles into a new state that it derives from the neighbours still holding a logic value.

One compile-time parameter picks the orientation. The row variant couples antiferromagnetically along its row, so an isolated upstream neighbour is inverted. The column variant couples ferromagnetically along its column, with its own priority and majority rules. Only the three immediate neighbours on the ports take part. A missing neighbour is modelled by tying its port to the clocked code. Cells are cascaded into wires and gates outside this block.

Top module: `magcell_node`

## Requirements
- R1: Codes are two bits: logic one 2'b11, logic zero 2'b00, clocked 2'b01, undecided 2'b10. While reset is low, and afterwards until the first command, `state_d_o` is 2'b01.
- R2: A `set_one_i` strobe makes `state_d_o` 2'b11 from the next rising edge. A `set_zero_i` strobe makes it 2'b00 from the next rising edge.
- R3: In a cycle with no command and no pending release, the state holds, whatever the neighbour ports carry.
- R4: While `park_i` is high, with no write strobe, `state_d_o` is 2'b01 from the next rising edge.
- R5: The new state is resolved on the first rising edge at which `park_i` is low after being high. Only the neighbour values present at that edge are used. Values seen while parked have no effect.
- R6: A neighbour port carrying 2'b01 or 2'b10 is dropped from the vote. If all three are dropped, the result is 2'b10.
- R7: Row variant (A, B, C = west, north, south), first match wins. A and B dropped gives C. A and C dropped gives B. Only A dropped gives B if B equals C, and 2'b10 otherwise. B and C dropped gives NOT A. Only B dropped gives C. Only C dropped gives B. With none dropped, the result is B·C + NOT A·(B XOR C).
- R8: Column variant, first match wins. A and B dropped gives C. A and C dropped gives NOT B. Only A dropped gives C. B and C dropped gives NOT A. Only B dropped gives C. Only C dropped gives NOT A if A equals B, and 2'b10 otherwise. With none dropped, the result is C·NOT B + NOT A·(NOT B + C).
- R9: When strobes coincide, `set_one_i` wins over `set_zero_i`, which wins over `park_i`. A park that loses to a write arms no release.
- R10: A resolved state is always 2'b11, 2'b00 or 2'b10, never the clocked code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| set_one_i | input | 1 | Write-one strobe |
| set_zero_i | input | 1 | Write-zero strobe |
| park_i | input | 1 | Park (clocking) command, level |
| nbr_a_i | input | 2 | Neighbour A state code |
| nbr_b_i | input | 2 | Neighbour B state code |
| nbr_c_i | input | 2 | Neighbour C state code |
| state_d_o | output | 2 | Registered cell state toward the downstream neighbour |

## Verification
The bench builds two instances side by side: one with `VERTICAL` at 0 (row rules) and one with `VERTICAL` at 1 (column rules). Both see identical stimulus. All 64 combinations of the three two-bit neighbour codes are resolved in both orientations, so every branch of each priority chain is reached, including undecided neighbours treated as dropped. Before each release, the neighbours are scrambled while the cell is parked, which exposes any resolution taken at the wrong edge. The west-one, north-zero, south-one pattern is checked by name: it settles to zero in the row and one in the column.

// File: rtl/magcell_pkg.sv
package magcell_pkg;

   typedef logic [1:0] mc_code_t;

   localparam mc_code_t MC_ZERO  = 2'b00;
   localparam mc_code_t MC_HELD  = 2'b01;
   localparam mc_code_t MC_UNDEC = 2'b10;
   localparam mc_code_t MC_ONE   = 2'b11;

   typedef enum logic [2:0] {
      CMD_IDLE    = 3'd0,
      CMD_ONE     = 3'd1,
      CMD_ZERO    = 3'd2,
      CMD_PARK    = 3'd3,
      CMD_RESOLVE = 3'd4
   } mc_cmd_e;

   // Turn a logic value into its two-bit cell code
   function automatic mc_code_t mc_pack(input logic v);
      return v ? MC_ONE : MC_ZERO;
   endfunction

endpackage

// File: rtl/magcell_sense.sv
module magcell_sense
   import magcell_pkg::*;
#(
   parameter int unsigned NPORT = 3,
   parameter int unsigned SW    = 2
) (
   input  logic [NPORT-1:0][SW-1:0] codes_i,
   output logic [NPORT-1:0]         live_o,
   output logic [NPORT-1:0]         val_o
);

   localparam int unsigned MSB = SW - 1;

   if (SW != 2) begin : g_bad_width
      $error("magcell_sense: SW must be 2");
   end

   for (genvar g = 0; g < NPORT; g++) begin : g_port
      always_comb begin
         // a neighbour votes only while it carries a settled logic value
         live_o[g] = (codes_i[g] == MC_ZERO) || (codes_i[g] == MC_ONE);
         val_o[g]  = codes_i[g][MSB];
      end
   end

endmodule

// File: rtl/magcell_resolve.sv
module magcell_resolve
   import magcell_pkg::*;
#(
   parameter bit VERTICAL = 1'b0
) (
   input  logic [2:0] live_i,
   input  logic [2:0] val_i,
   output mc_code_t   res_o
);

   logic la, lb, lc, va, vb, vc;

   always_comb begin
      la = live_i[0];
      lb = live_i[1];
      lc = live_i[2];
      va = val_i[0];
      vb = val_i[1];
      vc = val_i[2];
   end

   if (VERTICAL) begin : g_col
      always_comb begin
         if (!la && !lb && !lc)  res_o = MC_UNDEC;
         else if (!la && !lb)    res_o = mc_pack(vc);
         else if (!la && !lc)    res_o = mc_pack(!vb);
         else if (!la)           res_o = mc_pack(vc);
         else if (!lb && !lc)    res_o = mc_pack(!va);
         else if (!lb)           res_o = mc_pack(vc);
         else if (!lc)           res_o = (va == vb) ? mc_pack(!va) : MC_UNDEC;
         else                    res_o = mc_pack((vc & !vb) | (!va & (!vb | vc)));
      end
   end else begin : g_row
      always_comb begin
         if (!la && !lb && !lc)  res_o = MC_UNDEC;
         else if (!la && !lb)    res_o = mc_pack(vc);
         else if (!la && !lc)    res_o = mc_pack(vb);
         else if (!la)           res_o = (vb == vc) ? mc_pack(vb) : MC_UNDEC;
         else if (!lb && !lc)    res_o = mc_pack(!va);
         else if (!lb)           res_o = mc_pack(vc);
         else if (!lc)           res_o = mc_pack(vb);
         else                    res_o = mc_pack((vb & vc) | (!va & (vb ^ vc)));
      end
   end

endmodule

// File: rtl/magcell_cmd.sv
module magcell_cmd
   import magcell_pkg::*;
(
   input  logic    clk_i,
   input  logic    rst_ni,
   input  logic    set_one_i,
   input  logic    set_zero_i,
   input  logic    park_i,
   output mc_cmd_e cmd_o,
   output logic    release_o
);

   logic park_q;

   // a park only counts when no write outranks it
   always_ff @(posedge clk_i) begin
      if (!rst_ni) park_q <= 1'b0;
      else         park_q <= park_i && !set_one_i && !set_zero_i;
   end

   assign release_o = park_q;

   always_comb begin
      if (set_one_i)       cmd_o = CMD_ONE;
      else if (set_zero_i) cmd_o = CMD_ZERO;
      else if (park_i)     cmd_o = CMD_PARK;
      else if (park_q)     cmd_o = CMD_RESOLVE;
      else                 cmd_o = CMD_IDLE;
   end

endmodule

// File: rtl/magcell_node.sv
module magcell_node
   import magcell_pkg::*;
#(
   parameter bit          VERTICAL = 1'b0,
   parameter int unsigned SW       = 2,
   parameter int unsigned NPORT    = 3
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          set_one_i,
   input  logic          set_zero_i,
   input  logic          park_i,
   input  logic [SW-1:0] nbr_a_i,
   input  logic [SW-1:0] nbr_b_i,
   input  logic [SW-1:0] nbr_c_i,
   output logic [SW-1:0] state_d_o
);

   if (SW != 2) begin : g_bad_sw
      $error("magcell_node: SW must be 2");
   end
   if (NPORT != 3) begin : g_bad_nport
      $error("magcell_node: NPORT must be 3");
   end

   logic [NPORT-1:0][SW-1:0] codes;
   logic [NPORT-1:0]         live;
   logic [NPORT-1:0]         val;
   mc_code_t                 res;
   mc_cmd_e                  cmd;
   logic                     rel;
   mc_code_t                 state_q;

   assign codes = {nbr_c_i, nbr_b_i, nbr_a_i};

   magcell_sense #(.NPORT(NPORT), .SW(SW)) u_sense (
      .codes_i (codes),
      .live_o  (live),
      .val_o   (val)
   );

   magcell_resolve #(.VERTICAL(VERTICAL)) u_resolve (
      .live_i (live),
      .val_i  (val),
      .res_o  (res)
   );

   magcell_cmd u_cmd (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_one_i  (set_one_i),
      .set_zero_i (set_zero_i),
      .park_i     (park_i),
      .cmd_o      (cmd),
      .release_o  (rel)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= MC_HELD;
      end else begin
         unique case (cmd)
            CMD_ONE:     state_q <= MC_ONE;
            CMD_ZERO:    state_q <= MC_ZERO;
            CMD_PARK:    state_q <= MC_HELD;
            CMD_RESOLVE: state_q <= res;
            default:     state_q <= state_q;
         endcase
      end
   end

   assign state_d_o = state_q;

   logic quiet;
   assign quiet = !set_one_i && !set_zero_i && !park_i;

   p_set_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_one_i |=> state_d_o == MC_ONE);

   p_zero_beats_park_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_zero_i && !set_one_i) |=> state_d_o == MC_ZERO);

   p_park_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (park_i && !set_one_i && !set_zero_i) |=> state_d_o == MC_HELD);

   p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && !rel) |=> $stable(state_d_o));

   p_resolved_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && rel) |=> state_d_o != MC_HELD);

   p_all_dropped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (quiet && rel && live == '0) |=> state_d_o == MC_UNDEC);

endmodule

// File: tb/tb_magcell_node.sv
`timescale 1ns/1ps
module tb_magcell_node;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       s1 = 1'b0, s0 = 1'b0, pk = 1'b0;
   logic [1:0] na = 2'b01, nb = 2'b01, nc = 2'b01;
   logic [1:0] dh, dv;
   logic [1:0] mh, mv;
   logic       mpark;
   int         n_chk = 0, n_bad = 0;
   bit         run = 1'b0;
   string      tag = "R1";

   always #2.5 clk = ~clk;

   magcell_node #(.VERTICAL(1'b0)) dut (
      .clk_i(clk), .rst_ni(rst_n), .set_one_i(s1), .set_zero_i(s0), .park_i(pk),
      .nbr_a_i(na), .nbr_b_i(nb), .nbr_c_i(nc), .state_d_o(dh));

   magcell_node #(.VERTICAL(1'b1)) dut_v (
      .clk_i(clk), .rst_ni(rst_n), .set_one_i(s1), .set_zero_i(s0), .park_i(pk),
      .nbr_a_i(na), .nbr_b_i(nb), .nbr_c_i(nc), .state_d_o(dv));

   // reference rules from R6/R7/R8
   function automatic logic [1:0] expect_res(bit vert, logic [1:0] a, logic [1:0] b, logic [1:0] c);
      bit da, db, dc, xa, xb, xc, r;
      da = !(a == 2'b00 || a == 2'b11);
      db = !(b == 2'b00 || b == 2'b11);
      dc = !(c == 2'b00 || c == 2'b11);
      xa = a[1]; xb = b[1]; xc = c[1];
      if (!vert) begin
         case ({da, db, dc})
            3'b111: return 2'b10;
            3'b110: r = xc;
            3'b101: r = xb;
            3'b100: if (xb == xc) r = xb; else return 2'b10;
            3'b011: r = !xa;
            3'b010: r = xc;
            3'b001: r = xb;
            default: r = (xb && xc) || (!xa && (xb != xc));
         endcase
      end else begin
         case ({da, db, dc})
            3'b111: return 2'b10;
            3'b110: r = xc;
            3'b101: r = !xb;
            3'b100: r = xc;
            3'b011: r = !xa;
            3'b010: r = xc;
            3'b001: if (xa == xb) r = !xa; else return 2'b10;
            default: r = (xc && !xb) || (!xa && (!xb || xc));
         endcase
      end
      return r ? 2'b11 : 2'b00;
   endfunction

   // cycle model from R1..R5, R9
   always @(posedge clk) begin
      if (!rst_n) begin
         mh <= 2'b01; mv <= 2'b01; mpark <= 1'b0;
      end else begin
         if (s1)         begin mh <= 2'b11; mv <= 2'b11; end
         else if (s0)    begin mh <= 2'b00; mv <= 2'b00; end
         else if (pk)    begin mh <= 2'b01; mv <= 2'b01; end
         else if (mpark) begin mh <= expect_res(1'b0, na, nb, nc); mv <= expect_res(1'b1, na, nb, nc); end
         mpark <= pk && !s1 && !s0;
      end
   end

   task automatic check(input logic [1:0] act, input logic [1:0] exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) if (run) begin
      check(dh, mh, "row per-cycle");
      check(dv, mv, "column per-cycle");
   end

   task automatic step(input logic w1, input logic w0, input logic p);
      @(negedge clk);
      s1 = w1; s0 = w0; pk = p;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      check(dh, 2'b01, "row in reset");
      check(dv, 2'b01, "column in reset");
      rst_n = 1'b1;
      run = 1'b1;
      step(0, 0, 0); step(0, 0, 0);
      @(negedge clk);
      check(dh, 2'b01, "row after reset idle");
      // R2 / R3
      tag = "R2"; step(1, 0, 0); step(0, 0, 0);
      tag = "R3"; na = 2'b00; nb = 2'b00; nc = 2'b00;
      step(0, 0, 0); na = 2'b11; step(0, 0, 0);
      @(negedge clk); check(dh, 2'b11, "row hold after write one");
      tag = "R2"; step(0, 1, 0); step(0, 0, 0);
      tag = "R3"; nb = 2'b11; nc = 2'b11; step(0, 0, 0); step(0, 0, 0);
      @(negedge clk); check(dv, 2'b00, "column hold after write zero");
      // R9 priorities
      tag = "R9"; step(1, 1, 0); step(0, 1, 1); step(1, 1, 1);
      step(0, 0, 0); step(0, 0, 0);
      @(negedge clk); check(dh, 2'b11, "row write-one wins, no release");
      // R4 / R5 / R6 / R7 / R8 exhaustive
      for (int i = 0; i < 64; i++) begin
         tag = "R4";
         step(0, 0, 1);
         na = ~i[5:4]; nb = ~i[3:2]; nc = ~i[1:0];   // scramble while parked
         if (i % 3 == 0) step(0, 0, 1);
         tag = "R5 R6 R7 R8";
         step(0, 0, 0);
         na = i[5:4]; nb = i[3:2]; nc = i[1:0];
         step(0, 0, 0);
      end
      // named case: west=1 north=0 south=1
      tag = "R7";
      step(0, 0, 1);
      step(0, 0, 0); na = 2'b11; nb = 2'b00; nc = 2'b11;
      step(0, 0, 0);
      @(negedge clk);
      check(dh, 2'b00, "row W1 N0 S1");
      tag = "R8";
      check(dv, 2'b11, "column W1 N0 S1");
      tag = "R10";
      check({1'b0, dh == 2'b01}, 2'b00, "row not clocked after resolve");
      step(0, 0, 0);
      run = 1'b0;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule